// File: doc/BRIEF.md
# NAND Hamming ECC Syndrome Corrector

This block decides what to do with one 512-byte NAND data chunk once its three ECC bytes are known twice over: once as stored in the spare area, and once as recomputed while the data streamed in. Each 24-bit code is first spread into a 32-bit word. The two words are then XORed to form a syndrome, and the set bits of the syndrome are counted to sort the chunk into one of five outcomes. The outcomes are clean data, a correctable single-bit data error, a damaged ECC field, an erased (blank) page, or an uncorrectable error.

For a correctable error the block returns the byte offset inside the chunk and a one-hot mask. The surrounding data path XORs that mask into the byte. Computing the parity over the data and patching the buffer are done outside this block.

The block is a two-stage pipeline. A result comes out with a one-cycle done pulse two cycles after its start strobe, and a new pair of codes may be presented on every cycle.

Top module: `ecc_syn_corrector`

## Requirements
- R1: Each 24-bit code is spread into a 32-bit word before comparison. Input bits 7:0 (byte 0) go to word bits 7:0, and input bits 15:8 (byte 1) go to word bits 23:16. Input bits 19:16 (low nibble of byte 2) go to word bits 11:8, and input bits 23:20 (high nibble of byte 2) go to word bits 27:24. All other word bits are zero.
- R2: When the two spread words are equal (zero syndrome), status is 2'b00 and the erased flag is 0.
- R3: When the syndrome has exactly 12 set bits, status is 2'b01 (corrected). The bit index is syndrome bits 18:16, the byte offset is syndrome bits 27:19, and the mask is 8'b1 shifted left by the bit index.
- R4: When the syndrome has exactly 1 set bit, status is 2'b10 (ECC field damaged).
- R5: For any other nonzero count, a stored word of 32'h0FFF0FFF together with a computed word of 0 gives status 2'b00 with the erased flag set to 1.
- R6: Every remaining nonzero syndrome gives status 2'b11 (uncorrectable).
- R7: Whenever status is not 2'b01, the byte offset and the mask are zero.
- R8: done_o pulses for exactly one cycle, two clock cycles after start_i is sampled. A start is accepted on every cycle, each with its own result.
- R9: Reset clears done, status, the erased flag, the offset and the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Codes on the inputs are valid this cycle |
| stored_ecc_i | input | 24 | ECC bytes read from the spare area, byte 0 in bits 7:0 |
| calc_ecc_i | input | 24 | ECC bytes recomputed over the data, byte 0 in bits 7:0 |
| done_o | output | 1 | One-cycle pulse marking a valid result |
| status_o | output | 2 | 00 clean/erased, 01 corrected, 10 ECC damaged, 11 uncorrectable |
| erased_o | output | 1 | Chunk recognised as a blank page |
| fix_ofs_o | output | 9 | Byte offset to patch when corrected |
| fix_mask_o | output | 8 | One-hot mask to XOR into that byte when corrected |

## Verification
The block has no free parameters; the bench uses the fixed 24-bit code format and the 9-bit offset that a 512-byte chunk implies. This fixed size keeps a full sweep within reach: all 4096 byte/bit addresses of a true single-bit Hamming syndrome, all 24 single-bit syndromes and all 276 two-bit syndromes. These go back-to-back on consecutive cycles, so the pipeline stays full. Erased-page patterns and patterns one bit away from them probe the boundary between blank pages and uncorrectable errors.

// File: rtl/ecc_syn_pkg.sv
package ecc_syn_pkg;
  localparam int unsigned CODE_W   = 24;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BIT_W    = 3;
  localparam int unsigned OFS_W    = 9;
  localparam int unsigned MASK_W   = 1 << BIT_W;
  localparam int unsigned BIT_LSB  = 16;
  localparam int unsigned OFS_LSB  = BIT_LSB + BIT_W;
  localparam int unsigned POP_W    = $clog2(WORD_W + 1);
  localparam int unsigned SINGLE_POP = 12;
  localparam logic [WORD_W-1:0] BLANK_WORD = 32'h0FFF_0FFF;

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'b00,
    ST_FIXED  = 2'b01,
    ST_ECCBAD = 2'b10,
    ST_UNCORR = 2'b11
  } ecc_status_e;

  typedef struct packed {
    logic              vld;
    logic [WORD_W-1:0] syn;
    logic [POP_W-1:0]  pop;
    logic              blank;
  } syn_stage_t;
endpackage

// File: rtl/ecc_repack.sv
module ecc_repack
  import ecc_syn_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    word_o        = '0;
    word_o[7:0]   = code_i[7:0];
    word_o[23:16] = code_i[15:8];
    word_o[11:8]  = code_i[19:16];
    word_o[27:24] = code_i[23:20];
  end
endmodule

// File: rtl/ecc_syn_stage.sv
module ecc_syn_stage
  import ecc_syn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] stored_w_i,
  input  logic [WORD_W-1:0] calc_w_i,
  output syn_stage_t        stage_o
);
  syn_stage_t nxt;

  always_comb begin
    nxt.vld   = start_i;
    nxt.syn   = stored_w_i ^ calc_w_i;
    nxt.pop   = POP_W'($countones(nxt.syn));
    nxt.blank = (stored_w_i == BLANK_WORD) && (calc_w_i == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_o <= '0;
    else         stage_o <= nxt;
  end

  a_r8_stage_follows_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> stage_o.vld);
endmodule

// File: rtl/ecc_syn_classify.sv
module ecc_syn_classify
  import ecc_syn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  syn_stage_t        stage_i,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic              erased_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic [MASK_W-1:0] mask_o
);
  ecc_status_e       st_n;
  logic              er_n;
  logic [OFS_W-1:0]  ofs_n;
  logic [MASK_W-1:0] mask_n;
  logic [BIT_W-1:0]  bit_idx;

  assign bit_idx = stage_i.syn[BIT_LSB +: BIT_W];

  always_comb begin
    st_n   = ST_CLEAN;
    er_n   = 1'b0;
    ofs_n  = '0;
    mask_n = '0;
    if (stage_i.pop == POP_W'(SINGLE_POP)) begin
      st_n   = ST_FIXED;
      ofs_n  = stage_i.syn[OFS_LSB +: OFS_W];
      mask_n = MASK_W'(1) << bit_idx;
    end else if (stage_i.pop == POP_W'(1)) begin
      st_n = ST_ECCBAD;
    end else if (stage_i.pop != '0) begin
      if (stage_i.blank) er_n = 1'b1;
      else               st_n = ST_UNCORR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      status_o <= '0;
      erased_o <= 1'b0;
      ofs_o    <= '0;
      mask_o   <= '0;
    end else begin
      done_o <= stage_i.vld;
      if (stage_i.vld) begin
        status_o <= st_n;
        erased_o <= er_n;
        ofs_o    <= ofs_n;
        mask_o   <= mask_n;
      end
    end
  end

  a_r7_zero_unless_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != ST_FIXED) |-> (ofs_o == '0 && mask_o == '0));
  a_r3_mask_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_FIXED) |-> $onehot(mask_o));
  a_r5_erased_is_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erased_o |-> (status_o == ST_CLEAN));
endmodule

// File: rtl/ecc_syn_corrector.sv
module ecc_syn_corrector
  import ecc_syn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] stored_ecc_i,
  input  logic [CODE_W-1:0] calc_ecc_i,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic              erased_o,
  output logic [OFS_W-1:0]  fix_ofs_o,
  output logic [MASK_W-1:0] fix_mask_o
);
  logic [CODE_W-1:0] codes [2];
  logic [WORD_W-1:0] words [2];
  syn_stage_t        stage;

  assign codes[0] = stored_ecc_i;
  assign codes[1] = calc_ecc_i;

  for (genvar g = 0; g < 2; g++) begin : g_repack
    ecc_repack u_repack (.code_i(codes[g]), .word_o(words[g]));
  end

  ecc_syn_stage u_stage (
    .clk_i, .rst_ni, .start_i,
    .stored_w_i(words[0]), .calc_w_i(words[1]), .stage_o(stage)
  );

  ecc_syn_classify u_cls (
    .clk_i, .rst_ni, .stage_i(stage),
    .done_o, .status_o, .erased_o, .ofs_o(fix_ofs_o), .mask_o(fix_mask_o)
  );

  a_r8_done_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ##1 done_o);
  a_r8_no_spurious_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !stage.vld) |=> ##1 !done_o);
endmodule

// File: tb/ecc_syn_corrector_tb_top.sv
module ecc_syn_corrector_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] stored_ecc_i = '0;
  logic [23:0] calc_ecc_i = '0;
  logic        done_o;
  logic [1:0]  status_o;
  logic        erased_o;
  logic [8:0]  fix_ofs_o;
  logic [7:0]  fix_mask_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct packed {
    logic       vld;
    logic [1:0] st;
    logic       er;
    logic [8:0] ofs;
    logic [7:0] mask;
  } exp_t;

  exp_t pend1 = '0, pend2 = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ecc_syn_corrector dut_i (.*);

  // R1 layout, written from the requirement
  function automatic logic [31:0] spread(input logic [23:0] c);
    return {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
  endfunction

  function automatic logic [23:0] unspread(input logic [31:0] w);
    return {w[27:24], w[11:8], w[23:16], w[7:0]};
  endfunction

  function automatic exp_t predict(input logic [23:0] s, input logic [23:0] c);
    exp_t e;
    logic [31:0] x;
    int n;
    e = '0; e.vld = 1'b1;
    x = spread(s) ^ spread(c);
    n = $countones(x);
    if (n == 12) begin
      e.st = 2'b01; e.ofs = x[27:19]; e.mask = 8'd1 << x[18:16];
    end else if (n == 1) e.st = 2'b10;
    else if (n != 0) begin
      if (spread(s) == 32'h0FFF0FFF && spread(c) == 32'h0) e.er = 1'b1;
      else e.st = 2'b11;
    end
    return e;
  endfunction

  function automatic string tag_of(input exp_t e);
    if (e.st == 2'b01) return "R3 (R1 layout)";
    if (e.st == 2'b10) return "R4";
    if (e.st == 2'b11) return "R6";
    if (e.er) return "R5";
    return "R2";
  endfunction

  task automatic check_slot();
    checks++;
    if (!pend2.vld) begin
      if (done_o !== 1'b0) begin
        errors++;
        $display("FAIL R8 done act=%b exp=0", done_o);
      end
    end else if (done_o !== 1'b1) begin
      errors++;
      $display("FAIL R8 done act=%b exp=1", done_o);
    end else if (status_o !== pend2.st || erased_o !== pend2.er) begin
      errors++;
      $display("FAIL %s st/er act=%b/%b exp=%b/%b", tag_of(pend2),
               status_o, erased_o, pend2.st, pend2.er);
    end else if (fix_ofs_o !== pend2.ofs || fix_mask_o !== pend2.mask) begin
      errors++;
      $display("FAIL %s ofs/mask act=%h/%h exp=%h/%h",
               (pend2.st == 2'b01) ? "R3" : "R7",
               fix_ofs_o, fix_mask_o, pend2.ofs, pend2.mask);
    end
  endtask

  // one cycle: check the result of two cycles ago, then drive
  task automatic step(input logic go, input logic [23:0] s, input logic [23:0] c);
    @(negedge clk_i);
    check_slot();
    pend2 = pend1;
    pend1 = go ? predict(s, c) : '0;
    start_i = go; stored_ecc_i = s; calc_ecc_i = c;
  endtask

  task automatic flush();
    step(0, '0, '0);
    step(0, '0, '0);
    step(0, '0, '0);
  endtask

  task automatic reset_zero_check(input string when);
    checks++;
    if (done_o !== 0 || status_o !== 0 || erased_o !== 0 ||
        fix_ofs_o !== 0 || fix_mask_o !== 0) begin
      errors++;
      $display("FAIL R9 %s act=%b/%b/%b/%h/%h exp=0", when,
               done_o, status_o, erased_o, fix_ofs_o, fix_mask_o);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [23:0] base;
    logic [11:0] a;
    start_i = 1'b1; stored_ecc_i = 24'h123456;
    repeat (3) @(negedge clk_i);
    reset_zero_check("during reset");
    start_i = 1'b0;
    rst_ni = 1'b1;

    // R2 clean, several values
    for (int i = 0; i < 16; i++) begin
      base = 24'(i * 32'h9E3779);
      step(1, base, base);
    end
    flush();

    // R3 sweep of every byte/bit address of a true single-bit syndrome
    for (int i = 0; i < 4096; i++) begin
      a = 12'(i);
      base = 24'(i * 32'h2545F5);
      step(1, base ^ unspread({4'h0, a, 4'h0, ~a}), base);
    end
    flush();

    // R4 single-bit syndromes, R6 two-bit syndromes
    for (int i = 0; i < 24; i++) begin
      base = 24'h5A5A5A + 24'(i);
      step(1, base ^ (24'd1 << i), base);
    end
    for (int i = 0; i < 24; i++)
      for (int j = i + 1; j < 24; j++) begin
        base = 24'(i * 7919 + j * 104729);
        step(1, base, base ^ (24'd1 << i) ^ (24'd1 << j));
      end
    flush();

    // R5 erased page, and near misses that stay uncorrectable (R6)
    step(1, 24'hFFFFFF, 24'h000000);
    step(1, 24'hFFFFFF, 24'h000000);
    for (int i = 0; i < 24; i++) begin
      step(1, 24'hFFFFFF, 24'd1 << i);
      step(1, 24'hFFFFFF ^ (24'd3 << (i % 22)), 24'h000000);
    end
    step(1, 24'h000000, 24'hFFFFFF);
    // R3 any 12-bit syndrome counts as corrected, R7 after it returns to zero
    step(1, 24'h000FFF, 24'h000000);
    step(1, 24'hABCDEF, 24'hABCDEF);
    flush();

    // R9 reset with results in flight
    step(1, 24'h000001, 24'h000000);
    step(1, 24'hFFFFFF, 24'h000000);
    @(negedge clk_i);
    rst_ni = 1'b0; start_i = 1'b0;
    #1;
    reset_zero_check("mid-stream");
    @(negedge clk_i);
    rst_ni = 1'b1;
    pend1 = '0; pend2 = '0;
    flush();

    finish_run();
  end
endmodule